// File: doc/BRIEF.md
# Masked Vector Lane Insert Unit

This unit merges a narrow chunk into a wide vector. A 128-bit or 256-bit chunk from a second source replaces one lane-aligned region of a 512-bit-wide first source. The region is chosen by the low bits of an 8-bit immediate. Which bits are used depends on the vector length and the chunk size. Every region that is not replaced keeps the bits of the first source.

The combined vector then passes through per-element write masking. Elements are 32 or 64 bits wide. An element whose mask bit is clear either keeps the previous destination value or becomes zero. An unmasked mode writes every element.

The result and a valid flag are registered one clock after an input valid. With a 256-bit vector length, the upper half of the output is always zero.

Top module: `vec_lane_insert`

## Requirements
- R1: `out_valid` equals `in_valid` of the previous clock. `out_data` loads the new result on that same edge. A synchronous `rst` clears both `out_valid` and `out_data` to zero.
- R2: A 128-bit insert into a 256-bit vector (`vl512`=0, `wide_ins`=0) writes `src_b[127:0]` at bit offset 128·`imm[0]`. `imm[7:1]` has no effect.
- R3: A 128-bit insert into a 512-bit vector (`vl512`=1, `wide_ins`=0) writes `src_b[127:0]` at bit offset 128·`imm[1:0]`. `imm[7:2]` has no effect.
- R4: A 256-bit insert (`wide_ins`=1) writes `src_b[255:0]` at bit offset 256·`imm[0]`. `imm[7:1]` has no effect.
- R5: `wide_ins`=1 always implies a 512-bit vector length, whatever the value of `vl512`.
- R6: Every 128-bit lane that the insert does not replace equals the matching bits of `src_a`.
- R7: With `elem64`=0, element i is bits [32i+31:32i]. Mask bit i governs element i, for i = 0 to 15.
- R8: With `elem64`=1, element i is bits [64i+63:64i]. Mask bit i governs element i, for i = 0 to 7. `mask[15:8]` has no effect.
- R9: In masked mode (`unmasked`=0) with `zero_mode`=0, an element whose mask bit is clear takes its value from `prev_dst`.
- R10: In masked mode with `zero_mode`=1, an element whose mask bit is clear is zero.
- R11: With `unmasked`=1, every existing element holds the combined vector. `mask` and `zero_mode` have no effect.
- R12: With a 256-bit vector length, `out_data[511:256]` is zero. Mask bits for elements that do not exist have no effect.
- R13: While `in_valid` is low, `out_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input operands are valid this cycle |
| src_a | input | 512 | First source; supplies the lanes that are not replaced |
| src_b | input | 256 | Second source; supplies the inserted chunk (low 128 bits for narrow inserts) |
| imm | input | 8 | Immediate; its low bits pick the insert position |
| vl512 | input | 1 | 1: 512-bit vector length, 0: 256-bit |
| wide_ins | input | 1 | 1: 256-bit insert, 0: 128-bit insert |
| elem64 | input | 1 | 1: 64-bit elements, 0: 32-bit elements |
| mask | input | 16 | Per-element write mask, bit i for element i |
| zero_mode | input | 1 | 1: masked-off elements are zeroed, 0: merged from prev_dst |
| unmasked | input | 1 | 1: ignore the mask and write all elements |
| prev_dst | input | 512 | Previous destination value, used for merging |
| out_valid | output | 1 | Result valid |
| out_data | output | 512 | Registered result |

## Verification
Some properties are checked on every cycle:
- valid follows input valid with one cycle of delay;
- the output holds while no input is valid;
- the upper half is zero after a 256-bit-length operation;
- an all-zero mask in zeroing mode gives an all-zero result;
- exactly the right number of lanes is replaced for each insert size.

Other behaviour needs directed scenarios in the bench:
- the exact lane chosen by each immediate value, including high immediate bits that are set;
- which source fills each element under merge and zero masking;
- that the upper mask byte has no effect with 64-bit elements;
- that a 256-bit insert forces the full vector length.

// File: rtl/vli_pkg.sv
package vli_pkg;
    localparam int VLI_VEC_W  = 512;
    localparam int VLI_LANE_W = 128;
    localparam int VLI_ELEM_W = 32;
    localparam int VLI_IMM_W  = 8;
endpackage

// File: rtl/vli_lane_place.sv
module vli_lane_place
    import vli_pkg::*;
#(
    parameter int VEC_W  = VLI_VEC_W,
    parameter int LANE_W = VLI_LANE_W
) (
    input  logic [VEC_W-1:0]           src_a,
    input  logic [VEC_W/2-1:0]         src_b,
    input  logic [VLI_IMM_W-1:0]       imm,
    input  logic                       vl_full,
    input  logic                       wide,
    output logic [VEC_W-1:0]           combined,
    output logic [VEC_W/LANE_W-1:0]    lane_hit
);
    localparam int NUM_LANE   = VEC_W / LANE_W;
    localparam int HALF_LANES = NUM_LANE / 2;
    localparam int SEL_W      = $clog2(NUM_LANE);

    logic [SEL_W-1:0] nsel;

    // Narrow insert: in half-length mode the top select bit is dropped.
    always_comb begin
        nsel = imm[SEL_W-1:0];
        if (!vl_full) nsel[SEL_W-1] = 1'b0;
    end

    for (genvar k = 0; k < NUM_LANE; k++) begin : g_lane
        localparam int HALF_IDX = k / HALF_LANES;
        localparam int SUB_IDX  = k % HALF_LANES;
        assign lane_hit[k] = wide ? (imm[0] == 1'(HALF_IDX))
                                  : (nsel == SEL_W'(k));
        assign combined[k*LANE_W +: LANE_W] =
            !lane_hit[k] ? src_a[k*LANE_W +: LANE_W] :
            wide         ? src_b[SUB_IDX*LANE_W +: LANE_W] :
                           src_b[LANE_W-1:0];
    end

    // R3 R4: a narrow insert replaces one lane, a wide insert replaces half the lanes.
    always_comb begin
        if (!$isunknown({wide, vl_full, imm})) begin
            assert_lane_count_R4: assert ($countones(lane_hit) == (wide ? HALF_LANES : 1))
                else $error("lane hit count wrong");
        end
    end
endmodule

// File: rtl/vli_mask_apply.sv
module vli_mask_apply
    import vli_pkg::*;
#(
    parameter int VEC_W  = VLI_VEC_W,
    parameter int ELEM_W = VLI_ELEM_W
) (
    input  logic [VEC_W-1:0]        combined,
    input  logic [VEC_W-1:0]        prev,
    input  logic [VEC_W/ELEM_W-1:0] mask,
    input  logic                    e64,
    input  logic                    zero_mode,
    input  logic                    unmasked,
    input  logic                    vl_full,
    output logic [VEC_W-1:0]        result
);
    localparam int NUM_ELEM = VEC_W / ELEM_W;

    for (genvar j = 0; j < NUM_ELEM; j++) begin : g_elem
        localparam bit LOW_HALF = (j < NUM_ELEM / 2);
        localparam int WIDE_IDX = j / 2;
        logic mbit;
        logic present;
        assign mbit    = e64 ? mask[WIDE_IDX] : mask[j];
        assign present = vl_full || LOW_HALF;
        assign result[j*ELEM_W +: ELEM_W] =
            !present            ? '0 :
            (unmasked || mbit)  ? combined[j*ELEM_W +: ELEM_W] :
            zero_mode           ? '0 :
                                  prev[j*ELEM_W +: ELEM_W];
    end
endmodule

// File: rtl/vec_lane_insert.sv
module vec_lane_insert
    import vli_pkg::*;
#(
    parameter int VEC_W  = VLI_VEC_W,
    parameter int LANE_W = VLI_LANE_W,
    parameter int ELEM_W = VLI_ELEM_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [VEC_W-1:0]        src_a,
    input  logic [VEC_W/2-1:0]      src_b,
    input  logic [VLI_IMM_W-1:0]    imm,
    input  logic                    vl512,
    input  logic                    wide_ins,
    input  logic                    elem64,
    input  logic [VEC_W/ELEM_W-1:0] mask,
    input  logic                    zero_mode,
    input  logic                    unmasked,
    input  logic [VEC_W-1:0]        prev_dst,
    output logic                    out_valid,
    output logic [VEC_W-1:0]        out_data
);
    localparam int NUM_LANE = VEC_W / LANE_W;

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] data;
    } state_t;

    state_t st_d, st_q;
    logic vl_eff;
    logic [VEC_W-1:0] comb_vec;
    logic [VEC_W-1:0] masked_vec;
    logic [NUM_LANE-1:0] lane_hit;

    assign vl_eff = vl512 | wide_ins;

    vli_lane_place #(.VEC_W(VEC_W), .LANE_W(LANE_W)) u_place (
        .src_a    (src_a),
        .src_b    (src_b),
        .imm      (imm),
        .vl_full  (vl_eff),
        .wide     (wide_ins),
        .combined (comb_vec),
        .lane_hit (lane_hit)
    );

    vli_mask_apply #(.VEC_W(VEC_W), .ELEM_W(ELEM_W)) u_mask (
        .combined  (comb_vec),
        .prev      (prev_dst),
        .mask      (mask),
        .e64       (elem64),
        .zero_mode (zero_mode),
        .unmasked  (unmasked),
        .vl_full   (vl_eff),
        .result    (masked_vec)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) st_d.data = masked_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_data  = st_q.data;

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid) else $error("valid not raised");
    assert_valid_drops_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid) else $error("valid not dropped");
    assert_hold_idle_R13: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data)) else $error("data changed while idle");
    assert_upper_zero_R12: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !vl512 && !wide_ins) |=> (out_data[VEC_W-1:VEC_W/2] == '0))
        else $error("upper half not zero");
    assert_all_zeroed_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !unmasked && zero_mode && mask == '0) |=> (out_data == '0))
        else $error("zeroing left data");
endmodule

// File: tb/vec_lane_insert_test.sv
module vec_lane_insert_test;
    localparam int CLK_P = 10;

    typedef struct {
        logic [511:0] data;
        string        tag;
    } exp_t;

    logic         clk = 0;
    logic         rst = 1;
    logic         in_valid = 0;
    logic [511:0] src_a = '0;
    logic [255:0] src_b = '0;
    logic [7:0]   imm = '0;
    logic         vl512 = 0, wide_ins = 0, elem64 = 0;
    logic [15:0]  mask = '0;
    logic         zero_mode = 0, unmasked = 0;
    logic [511:0] prev_dst = '0;
    logic         out_valid;
    logic [511:0] out_data;

    int checks = 0;
    int errors = 0;
    bit armed = 0;
    bit done = 0;
    exp_t exp_q[$];
    logic [511:0] last_out;

    always #(CLK_P/2) clk = ~clk;

    vec_lane_insert uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
        .imm(imm), .vl512(vl512), .wide_ins(wide_ins), .elem64(elem64), .mask(mask),
        .zero_mode(zero_mode), .unmasked(unmasked), .prev_dst(prev_dst),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [511:0] model(
        logic [511:0] a, logic [255:0] b, logic [7:0] im, logic vl, logic wd,
        logic e64, logic [15:0] m, logic z, logic um, logic [511:0] pv);
        logic [511:0] c;
        logic [511:0] r;
        logic full;
        int pos;
        bit en;
        full = vl | wd;
        c = a;
        if (wd) begin
            pos = im[0] ? 256 : 0;
            c[pos +: 256] = b;
        end else begin
            pos = full ? 128 * int'(im[1:0]) : 128 * int'(im[0]);
            c[pos +: 128] = b[127:0];
        end
        r = '0;
        for (int j = 0; j < 16; j++) begin
            if (!full && j >= 8) continue;
            en = um ? 1'b1 : (e64 ? m[j/2] : m[j]);
            if (en)      r[j*32 +: 32] = c[j*32 +: 32];
            else if (!z) r[j*32 +: 32] = pv[j*32 +: 32];
        end
        return r;
    endfunction

    task automatic issue(string tag, logic [7:0] im, logic vl, logic wd, logic e64,
                         logic [15:0] m, logic z, logic um);
        exp_t e;
        imm = im; vl512 = vl; wide_ins = wd; elem64 = e64;
        mask = m; zero_mode = z; unmasked = um;
        in_valid = 1;
        e.data = model(src_a, src_b, im, vl, wd, e64, m, z, um, prev_dst);
        e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        in_valid = 0;
    endtask

    // Monitor: compares each result against the scoreboard queue.
    always @(negedge clk) begin
        if (armed) begin
            if (out_valid) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R1 unexpected valid: actual %h expected none", out_data);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (out_data !== e.data) begin
                        errors++;
                        $display("FAIL %s: actual %h expected %h", e.tag, out_data, e.data);
                    end
                end
            end else begin
                checks++;
                if (out_data !== last_out) begin
                    errors++;
                    $display("FAIL R13 idle hold: actual %h expected %h", out_data, last_out);
                end
            end
            last_out = out_data;
        end
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int j = 0; j < 16; j++) begin
            src_a[j*32 +: 32]    = 32'hA000_0000 + j;
            prev_dst[j*32 +: 32] = 32'hC000_0000 + j;
        end
        for (int j = 0; j < 8; j++) src_b[j*32 +: 32] = 32'hB000_0000 + j;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_data !== '0) begin
            errors++;
            $display("FAIL R1 reset state: actual %b/%h expected 0/0", out_valid, out_data);
        end
        last_out = out_data;
        armed = 1;

        // R2: narrow into 256, high imm bits set but ignored
        issue("R2 lane0", 8'hFE, 0, 0, 0, 16'h0000, 0, 1);
        issue("R2 lane1", 8'h01, 0, 0, 0, 16'h0000, 0, 1);
        issue("R2 ignore high", 8'h03, 0, 0, 0, 16'h0000, 0, 1);
        // R3 and R6: each of four lanes, imm[7:2] set
        for (int k = 0; k < 4; k++)
            issue("R3/R6 lane", 8'hFC | 8'(k), 1, 0, 0, 16'h0000, 0, 1);
        // R4: wide insert, both halves
        issue("R4 low half", 8'hFE, 1, 1, 0, 16'h0000, 0, 1);
        issue("R4 high half", 8'h01, 1, 1, 1, 16'h0000, 0, 1);
        // R5: wide insert with vl512 low
        issue("R5 forced full", 8'h01, 0, 1, 0, 16'h0000, 0, 1);
        repeat (2) @(negedge clk);   // R13 idle gap
        // R7: 32-bit mask, merge
        issue("R7 elem32", 8'h02, 1, 0, 0, 16'hA5C3, 0, 0);
        // R8: 64-bit mask, upper byte ignored
        issue("R8 elem64", 8'h01, 1, 1, 1, 16'hFF5A, 0, 0);
        issue("R8 elem64 zero", 8'h03, 1, 0, 1, 16'hFF00, 1, 0);
        // R9: merge
        issue("R9 merge", 8'h00, 1, 0, 0, 16'h0F0F, 0, 0);
        // R10: zeroing
        issue("R10 zero", 8'h01, 1, 1, 0, 16'h3C3C, 1, 0);
        issue("R10 all zero", 8'h02, 1, 0, 0, 16'h0000, 1, 0);
        // R11: unmasked ignores mask and zeroing
        issue("R11 unmasked", 8'h01, 1, 0, 0, 16'h0000, 1, 1);
        // R12: 256 length, high mask bits ignored, upper output zero
        issue("R12 half len", 8'h01, 0, 0, 0, 16'hFF00, 0, 0);
        issue("R12 half len e64", 8'h00, 0, 0, 1, 16'hFFF3, 1, 0);
        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R1 missing results: actual %0d pending expected 0", exp_q.size());
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule